// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This block collects the interrupt causes of a UART receiver and transmitter and turns them into a single prioritized identification word that the CPU reads. The causes are receive line errors, receive data available, character timeout, transmit holding register empty and modem status. There are also two auto-baud flags, which are reported in their own bits. Each cause has an enable bit. The block drives an interrupt request line whenever an enabled cause is pending.

A read of the identification word is signalled by holding `iirRead` high for one or more cycles. On the first cycle of the access, the reported word is captured into `readData`. It then stays frozen for the rest of the access and afterwards. Anything that happens during the access is recorded and shows up on the next read.

Some causes are sticky and are cleared by specific actions:
- A receive line error is cleared only by a line status read (`lsrRead`).
- A transmit-empty cause is cleared when a read reports it.
- The auto-baud flags are cleared only by their own clear inputs.

Top module: `uart_iid`

## Requirements
- R1: During and straight after reset, `readData` is 32'h0000_0001 and `irq` is 0.
- R2: Bit 0 of the word is 0 when any enabled non-auto-baud cause is pending. Bits 3:1 then give the highest-priority cause: line error 011, data available 010, character timeout 110, transmit empty 001, modem 000. The priority order is line error > data available/timeout > transmit empty > modem.
- R3: When data available and character timeout are both pending and enabled, the word reports data available (010).
- R4: The enable mapping is `intEnable[0]` for data available and timeout, `[1]` for transmit empty, `[2]` for line error and `[3]` for modem. A cause whose enable bit is 0 is neither reported nor able to raise `irq`.
- R5: A pulse on any bit of `rxErr` (overrun, parity, framing, break) latches the line error cause. The cause persists until an `lsrRead` pulse. An error in the same cycle as `lsrRead` keeps the cause set.
- R6: The word is captured on the first cycle of `iirRead` high and held unchanged until the next access begins. A cause that arrives during an access is reported by the next access.
- R7: An access that reports transmit empty (001) clears that cause. An access that reports any other code leaves it pending. A `txEmptyEvent` in the capture cycle keeps it pending.
- R8: Bits 7:6 of the word both equal `fifoEnable` at the capture cycle.
- R9: Bit 8 is `abDoneFlag & abDoneEn` and bit 9 is `abToFlag & abToEn`. Each flag is set by its set pulse and cleared only by its clear pulse; a read does not clear it. Neither flag affects bit 0.
- R10: With no enabled non-auto-baud cause pending, bits 3:0 read 0001. Bits 5:4 and 31:10 always read 0.
- R11: `irq` is 1 exactly when an enabled non-auto-baud cause is pending, or an auto-baud flag is set with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| intEnable | input | 4 | Per-cause enables (see R4) |
| rxErr | input | 4 | Receive error pulses: overrun, parity, framing, break |
| rxDataAvail | input | 1 | Receive data available level |
| rxTimeout | input | 1 | Character timeout level |
| txEmptyEvent | input | 1 | Pulse when the transmit holding register becomes empty |
| modemPend | input | 1 | Modem status change level |
| iirRead | input | 1 | High for the duration of an identification word access |
| lsrRead | input | 1 | Line status read pulse |
| abDoneSet | input | 1 | Auto-baud finished pulse |
| abDoneClr | input | 1 | Auto-baud finished clear pulse |
| abDoneEn | input | 1 | Auto-baud finished report enable |
| abToSet | input | 1 | Auto-baud timeout pulse |
| abToClr | input | 1 | Auto-baud timeout clear pulse |
| abToEn | input | 1 | Auto-baud timeout report enable |
| fifoEnable | input | 1 | FIFO enable control bit, mirrored in bits 7:6 |
| readData | output | 32 | Captured identification word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a cause that arrives while an access is still in progress. It has to leave the held word untouched and still appear on the following read. A transmit-empty event that lands exactly on the capture cycle of a read reporting 001 is the sharpest form of this. Directed sequences build both cases cycle by cycle. Random traffic then mixes multi-cycle accesses with error, transmit and auto-baud pulses, so that coincident set and clear cycles also occur by chance.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

  localparam int ERR_W  = 4;
  localparam int EN_W   = 4;
  localparam int ID_W   = 3;

  // enable bit positions
  localparam int EN_RXDATA = 0;
  localparam int EN_TXEMPTY = 1;
  localparam int EN_LINE   = 2;
  localparam int EN_MODEM  = 3;

  // word field positions
  localparam int PEND_BIT    = 0;
  localparam int ID_LSB      = 1;
  localparam int FIFO_LSB    = 6;
  localparam int AB_DONE_BIT = 8;
  localparam int AB_TO_BIT   = 9;

  localparam logic [ID_W-1:0] ID_LINE    = 3'b011;
  localparam logic [ID_W-1:0] ID_RXDATA  = 3'b010;
  localparam logic [ID_W-1:0] ID_TIMEOUT = 3'b110;
  localparam logic [ID_W-1:0] ID_TXEMPTY = 3'b001;
  localparam logic [ID_W-1:0] ID_MODEM   = 3'b000;

  typedef struct packed {
    logic snap;
    logic hold;
    logic lineSet;
    logic lineClr;
    logic abDoneSet;
    logic abDoneClr;
    logic abToSet;
    logic abToClr;
  } ctrlStrobe_t;

endpackage

// File: rtl/uart_iid_ctrl.sv
module uart_iid_ctrl
  import uart_iid_pkg::*;
#(
  parameter int NUM_ERR = ERR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               iirRead,
  input  logic               lsrRead,
  input  logic [NUM_ERR-1:0] rxErr,
  input  logic               abDoneSet,
  input  logic               abDoneClr,
  input  logic               abToSet,
  input  logic               abToClr,
  output ctrlStrobe_t        strb
);

  logic readQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readQ <= 1'b0;
    else       readQ <= iirRead;
  end

  always_comb begin
    strb.snap      = iirRead & ~readQ;
    strb.hold      = iirRead & readQ;
    strb.lineSet   = |rxErr;
    strb.lineClr   = lsrRead;
    strb.abDoneSet = abDoneSet;
    strb.abDoneClr = abDoneClr;
    strb.abToSet   = abToSet;
    strb.abToClr   = abToClr;
  end

  // capture happens once per access
  p_single_snap_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.snap |=> !strb.snap);

  p_hold_follows_snap_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.snap && iirRead |=> strb.hold || !iirRead);

endmodule

// File: rtl/uart_iid_datapath.sv
module uart_iid_datapath
  import uart_iid_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [EN_W-1:0]   intEnable,
  input  logic              rxDataAvail,
  input  logic              rxTimeout,
  input  logic              txEmptyEvent,
  input  logic              modemPend,
  input  logic              abDoneEn,
  input  logic              abToEn,
  input  logic              fifoEnable,
  output logic [DATA_W-1:0] readData,
  output logic              irq
);

  localparam logic [DATA_W-1:0] RESET_WORD = DATA_W'(1) << PEND_BIT;

  logic lineQ, txQ, abDoneQ, abToQ;
  logic anyPend;
  logic [ID_W-1:0] curId;
  logic [DATA_W-1:0] word;
  logic abDoneVis, abToVis;

  // priority selection
  always_comb begin
    anyPend = 1'b1;
    curId   = ID_MODEM;
    if (lineQ && intEnable[EN_LINE])                curId = ID_LINE;
    else if (rxDataAvail && intEnable[EN_RXDATA])   curId = ID_RXDATA;
    else if (rxTimeout && intEnable[EN_RXDATA])     curId = ID_TIMEOUT;
    else if (txQ && intEnable[EN_TXEMPTY])          curId = ID_TXEMPTY;
    else if (modemPend && intEnable[EN_MODEM])      curId = ID_MODEM;
    else begin
      anyPend = 1'b0;
      curId   = '0;
    end
  end

  assign abDoneVis = abDoneQ & abDoneEn;
  assign abToVis   = abToQ & abToEn;

  always_comb begin
    word = '0;
    word[PEND_BIT] = ~anyPend;
    word[ID_LSB +: ID_W] = curId;
    word[FIFO_LSB +: 2] = {2{fifoEnable}};
    word[AB_DONE_BIT] = abDoneVis;
    word[AB_TO_BIT] = abToVis;
  end

  assign irq = anyPend | abDoneVis | abToVis;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ    <= 1'b0;
      txQ      <= 1'b0;
      abDoneQ  <= 1'b0;
      abToQ    <= 1'b0;
      readData <= RESET_WORD;
    end else begin
      lineQ   <= (lineQ & ~strb.lineClr) | strb.lineSet;
      txQ     <= (txQ & ~(strb.snap & anyPend & (curId == ID_TXEMPTY))) | txEmptyEvent;
      abDoneQ <= (abDoneQ & ~strb.abDoneClr) | strb.abDoneSet;
      abToQ   <= (abToQ & ~strb.abToClr) | strb.abToSet;
      if (strb.snap) readData <= word;
    end
  end

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.hold |=> $stable(readData));

  p_line_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    lineQ && !strb.lineClr |=> lineQ);

  p_line_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.lineClr && !strb.lineSet |=> !lineQ);

  p_abdone_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    abDoneQ && !strb.abDoneClr |=> abDoneQ);

  p_idle_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    readData[PEND_BIT] |-> readData[ID_LSB +: ID_W] == 3'b000);

  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    readData[5:4] == 2'b00 && readData[DATA_W-1:AB_TO_BIT+1] == '0);

  p_tx_cleared_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.snap && anyPend && curId == ID_TXEMPTY && !txEmptyEvent |=> !txQ);

endmodule

// File: rtl/uart_iid.sv
module uart_iid
  import uart_iid_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EN_W-1:0]   intEnable,
  input  logic [ERR_W-1:0]  rxErr,
  input  logic              rxDataAvail,
  input  logic              rxTimeout,
  input  logic              txEmptyEvent,
  input  logic              modemPend,
  input  logic              iirRead,
  input  logic              lsrRead,
  input  logic              abDoneSet,
  input  logic              abDoneClr,
  input  logic              abDoneEn,
  input  logic              abToSet,
  input  logic              abToClr,
  input  logic              abToEn,
  input  logic              fifoEnable,
  output logic [DATA_W-1:0] readData,
  output logic              irq
);

  ctrlStrobe_t strb;

  uart_iid_ctrl #(.NUM_ERR(ERR_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .iirRead   (iirRead),
    .lsrRead   (lsrRead),
    .rxErr     (rxErr),
    .abDoneSet (abDoneSet),
    .abDoneClr (abDoneClr),
    .abToSet   (abToSet),
    .abToClr   (abToClr),
    .strb      (strb)
  );

  uart_iid_datapath #(.DATA_W(DATA_W)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .intEnable    (intEnable),
    .rxDataAvail  (rxDataAvail),
    .rxTimeout    (rxTimeout),
    .txEmptyEvent (txEmptyEvent),
    .modemPend    (modemPend),
    .abDoneEn     (abDoneEn),
    .abToEn       (abToEn),
    .fifoEnable   (fifoEnable),
    .readData     (readData),
    .irq          (irq)
  );

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    intEnable == '0 && !abDoneEn && !abToEn |-> !irq);

endmodule

// File: tb/tb_uart_iid.sv
module tb_uart_iid;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  intEnable = '0;
  logic [3:0]  rxErr = '0;
  logic        rxDataAvail = 0, rxTimeout = 0, txEmptyEvent = 0, modemPend = 0;
  logic        iirRead = 0, lsrRead = 0;
  logic        abDoneSet = 0, abDoneClr = 0, abDoneEn = 0;
  logic        abToSet = 0, abToClr = 0, abToEn = 0, fifoEnable = 0;
  logic [31:0] readData;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;

  // bench model state
  logic mLine = 0, mTx = 0, mAbD = 0, mAbT = 0, mPrevRead = 0;
  logic [31:0] mWord = 32'h1;

  always #10 clk = ~clk;

  uart_iid dut (.*);

  function automatic logic [3:0] selCode(input logic line, input logic tx);
    // returns {pending, id}
    if (line && intEnable[2])                  return {1'b1, 3'b011};
    else if (rxDataAvail && intEnable[0])      return {1'b1, 3'b010};
    else if (rxTimeout && intEnable[0])        return {1'b1, 3'b110};
    else if (tx && intEnable[1])               return {1'b1, 3'b001};
    else if (modemPend && intEnable[3])        return {1'b1, 3'b000};
    else                                       return 4'b0000;
  endfunction

  function automatic logic [31:0] expWord();
    logic [3:0] s;
    logic [31:0] w;
    s = selCode(mLine, mTx);
    w = '0;
    w[0] = ~s[3];
    w[3:1] = s[2:0];
    w[7:6] = {2{fifoEnable}};
    w[8] = mAbD & abDoneEn;
    w[9] = mAbT & abToEn;
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: model next state, wait, compare, release pulses
  task automatic cyc(input string tag);
    logic snap, nLine, nTx, nAbD, nAbT;
    logic [3:0] s;
    logic [31:0] nWord;
    snap = iirRead & ~mPrevRead;
    s = selCode(mLine, mTx);
    nWord = snap ? expWord() : mWord;
    nLine = (mLine & ~lsrRead) | (|rxErr);
    nTx = (mTx & ~(snap & s[3] & (s[2:0] == 3'b001))) | txEmptyEvent;
    nAbD = (mAbD & ~abDoneClr) | abDoneSet;
    nAbT = (mAbT & ~abToClr) | abToSet;
    @(negedge clk);
    mLine = nLine; mTx = nTx; mAbD = nAbD; mAbT = nAbT;
    mWord = nWord; mPrevRead = iirRead;
    check({tag, " word"}, readData, mWord);
    s = selCode(mLine, mTx);
    check("R11 irq", {31'b0, irq}, {31'b0, s[3] | (mAbD & abDoneEn) | (mAbT & abToEn)});
    rxErr = '0; txEmptyEvent = 0; lsrRead = 0;
    abDoneSet = 0; abDoneClr = 0; abToSet = 0; abToClr = 0;
  endtask

  task automatic readOnce(input string tag);
    iirRead = 1; cyc(tag);
    iirRead = 0; cyc(tag);
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1 reset
    repeat (3) @(negedge clk);
    check("R1 reset word", readData, 32'h1);
    check("R1 reset irq", {31'b0, irq}, 32'h0);
    rstN = 1;
    cyc("R1 after reset");

    // R10 idle read with fifo bits, R8
    fifoEnable = 1;
    readOnce("R8 R10 idle");
    check("R10 idle low nibble", {28'b0, readData[3:0]}, 32'h1);
    check("R8 fifo bits", {30'b0, readData[7:6]}, 32'h3);

    // R4 disabled source ignored
    rxDataAvail = 1; modemPend = 1;
    readOnce("R4 disabled");
    check("R4 not reported", {31'b0, readData[0]}, 32'h1);
    check("R4 no irq", {31'b0, irq}, 32'h0);

    // R3 data available beats timeout
    intEnable = 4'b1111; rxTimeout = 1;
    readOnce("R3 both");
    check("R3 code 010", {29'b0, readData[3:1]}, 32'h2);
    rxDataAvail = 0;
    readOnce("R2 timeout");
    check("R2 code 110", {29'b0, readData[3:1]}, 32'h6);
    rxTimeout = 0;

    // R5 each error latches, lsrRead clears
    for (int i = 0; i < 4; i++) begin
      rxErr = 4'b1 << i; cyc("R5 err");
      cyc("R5 hold");
      readOnce("R5 read");
      check("R5 line code", {29'b0, readData[3:1]}, 32'h3);
      lsrRead = 1; cyc("R5 clear");
      readOnce("R5 after clear");
      check("R5 modem now", {28'b0, readData[3:0]}, 32'h0);
    end
    lsrRead = 1; rxErr = 4'b0100; cyc("R5 coincident");
    readOnce("R5 coincident read");
    check("R5 set wins", {29'b0, readData[3:1]}, 32'h3);
    lsrRead = 1; cyc("R5 clr");
    modemPend = 0;

    // R7 tx empty cleared by its read, kept on event in capture cycle
    txEmptyEvent = 1; cyc("R7 set");
    readOnce("R7 first");
    check("R7 code 001", {29'b0, readData[3:1]}, 32'h1);
    readOnce("R7 second");
    check("R7 cleared", {31'b0, readData[0]}, 32'h1);
    txEmptyEvent = 1; cyc("R7 set2");
    iirRead = 1; txEmptyEvent = 1; cyc("R7 coincident");
    iirRead = 0; cyc("R7 rel");
    readOnce("R7 after coincident");
    check("R7 still pending", {29'b0, readData[3:1]}, 32'h1);
    readOnce("R7 drain");
    txEmptyEvent = 1; rxErr = 4'b0001; cyc("R7 masked");
    readOnce("R7 line reported");
    lsrRead = 1; cyc("R7 lsr");
    readOnce("R7 tx survives");
    check("R7 tx kept", {29'b0, readData[3:1]}, 32'h1);
    readOnce("R7 drain2");

    // R6 event during multi-cycle access
    iirRead = 1; cyc("R6 start");
    rxErr = 4'b1000; cyc("R6 mid");
    cyc("R6 held");
    check("R6 frozen idle", {31'b0, readData[0]}, 32'h1);
    iirRead = 0; cyc("R6 end");
    readOnce("R6 next");
    check("R6 next line", {29'b0, readData[3:1]}, 32'h3);
    lsrRead = 1; cyc("R6 clr");

    // R9 auto-baud flags
    abDoneSet = 1; abToSet = 1; abDoneEn = 1; cyc("R9 set");
    readOnce("R9 read");
    check("R9 bits", {22'b0, readData[9:8], 8'b0}, 32'h100);
    check("R9 pend bit", {31'b0, readData[0]}, 32'h1);
    abToEn = 1;
    readOnce("R9 not read-cleared");
    check("R9 both", {22'b0, readData[9:8], 8'b0}, 32'h300);
    abDoneClr = 1; cyc("R9 clr");
    readOnce("R9 after clr");
    check("R9 done gone", {22'b0, readData[9:8], 8'b0}, 32'h200);
    abToClr = 1; cyc("R9 clr2");

    // random traffic
    void'($urandom(32'h1234abcd));
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 9) == 0) intEnable = 4'($urandom);
      if ($urandom_range(0, 7) == 0) rxDataAvail = ~rxDataAvail;
      if ($urandom_range(0, 7) == 0) rxTimeout = ~rxTimeout;
      if ($urandom_range(0, 9) == 0) modemPend = ~modemPend;
      if ($urandom_range(0, 15) == 0) fifoEnable = ~fifoEnable;
      if ($urandom_range(0, 15) == 0) abDoneEn = ~abDoneEn;
      if ($urandom_range(0, 15) == 0) abToEn = ~abToEn;
      if ($urandom_range(0, 3) == 0) iirRead = ~iirRead;
      if ($urandom_range(0, 11) == 0) rxErr = 4'($urandom);
      txEmptyEvent = ($urandom_range(0, 7) == 0);
      lsrRead = ($urandom_range(0, 9) == 0);
      abDoneSet = ($urandom_range(0, 19) == 0);
      abDoneClr = ($urandom_range(0, 19) == 0);
      abToSet = ($urandom_range(0, 19) == 0);
      abToClr = ($urandom_range(0, 19) == 0);
      cyc("R2 random");
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule